// File: doc/BRIEF.md
# Hot-Plug Status and Interrupt Controller

This block watches two connection indications of a display link: a raw hot-plug detect input that arrives straight from a connector, and a receiver-present indication produced elsewhere on the chip. It keeps one live status bit for each of them. The hot-plug input is cleaned by a digital debounce state machine before its status bit moves, while the receiver-present input only needs re-timing into the system clock.

Every change of a status bit, in either direction, sets a sticky event bit. Software reads the live status, the events and a per-event enable mask through a small synchronous register port, and clears events by writing ones. The interrupt output is asserted low whenever any event is pending together with its enable. It is presented as an open-drain drive request: `irq_drive_low` high means the pad should pull the shared interrupt line low.

The debounce machine has four states. DB_LOW and DB_HIGH are the settled levels. DB_RISE and DB_FALL are the trial states. The transitions are: LOW_TO_RISE when the input reads high in DB_LOW; RISE_ABORT back to DB_LOW when it reads low before the count completes; RISE_DONE into DB_HIGH when the last of N consecutive high samples is seen; and the mirror transitions HIGH_TO_FALL, FALL_ABORT and FALL_DONE. In DB_RISE and DB_FALL the reported status keeps the level it had before the trial.

Top module: `hpd_irq_ctrl`

## Requirements
- R1: After reset the status, event and enable registers all read 0x00 and `irq_drive_low` is 0.
- R2: Address 0 is the status register and is read-only. Bit 0 is receiver-present, bit 1 is hot-plug-connected and bits 7:2 read 0. A write to it changes nothing.
- R3: The hot-plug status bit (status bit 1) takes a new level only after the two-flop re-timed input has shown that level on DEB_CYCLES consecutive clocks. A pulse shorter than that leaves the status bit and the event bits unchanged.
- R4: The receiver-present input is re-timed by two flops without debounce. Status bit 0 takes the new level on the third rising clock edge after the input changes.
- R5: A change of status bit 0 sets event bit 0, and a change of status bit 1 sets event bit 1, on the same edge as the status change. Rising and falling changes both set the event. The event register is at address 1 and bits 7:2 read 0.
- R6: Event bits are sticky. Writing 1 to an event bit at address 1 clears it. Writing 0 leaves it unchanged.
- R7: The enable register at address 2 holds enable bit 0 (receiver event) and enable bit 1 (hot-plug event). It reads back in bits 1:0, and bits 7:2 read 0. Enables never affect whether event bits are set.
- R8: `irq_drive_low` is 1 exactly while some event bit and its enable bit are both 1.
- R9: When a status change and a write-1-to-clear hit the same event bit on the same clock edge, the event bit ends up set.
- R10: Addresses other than 0, 1 and 2 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hpd_raw | input | 1 | Raw hot-plug detect level from the connector, asynchronous |
| rx_present | input | 1 | Receiver-connected indication, asynchronous |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational from registers |
| irq_drive_low | output | 1 | Open-drain interrupt request: 1 pulls the active-low interrupt line low |

## Verification
The colliding pair is a status-change event set and a software write-1-to-clear of the same event bit. The bench provokes the collision by changing the receiver-present input at a known falling edge. It then holds a clear-write of event bit 0 across the third rising edge after that change, because R4 fixes that edge as the one where the status bit flips. The event register, read straight afterwards, must show the bit set. A second plain clear must then remove it, which shows that the first clear was really overridden and was not simply missed.

// File: rtl/hpd_pkg.sv
package hpd_pkg;

    typedef enum logic [1:0] {
        DB_LOW  = 2'd0,
        DB_RISE = 2'd1,
        DB_HIGH = 2'd2,
        DB_FALL = 2'd3
    } db_state_t;

    localparam int ADR_STAT = 0;
    localparam int ADR_EVT  = 1;
    localparam int ADR_EN   = 2;

    localparam int BIT_RX = 0;
    localparam int BIT_HP = 1;
    localparam int NUM_SRC = 2;

endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/hpd_debounce.sv
module hpd_debounce
    import hpd_pkg::*;
#(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic toggle_now
);
    localparam int CNT_W = $clog2(DEB_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

    db_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DB_LOW:  if (din) state_d = DB_RISE;                       // LOW_TO_RISE
            DB_RISE: if (!din) state_d = DB_LOW;                       // RISE_ABORT
                     else if (cnt_q == CNT_LAST) state_d = DB_HIGH;    // RISE_DONE
            DB_HIGH: if (!din) state_d = DB_FALL;                      // HIGH_TO_FALL
            DB_FALL: if (din) state_d = DB_HIGH;                       // FALL_ABORT
                     else if (cnt_q == CNT_LAST) state_d = DB_LOW;     // FALL_DONE
            default: state_d = DB_LOW;
        endcase
    end

    // state register and qualification counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == DB_LOW && din) || (state_q == DB_HIGH && !din))
                cnt_q <= CNT_W'(1);
            else if ((state_q == DB_RISE && din) || (state_q == DB_FALL && !din))
                cnt_q <= cnt_q + CNT_W'(1);
            else
                cnt_q <= '0;
        end
    end

    // outputs
    always_comb begin
        level      = (state_q == DB_HIGH) || (state_q == DB_FALL);
        toggle_now = (state_q == DB_RISE && state_d == DB_HIGH) ||
                     (state_q == DB_FALL && state_d == DB_LOW);
    end

    p_rise_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level) |-> ($past(state_q) == DB_RISE && $past(cnt_q) == CNT_LAST));

    p_bounce_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DB_RISE && !din) |=> !level);

    p_fall_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level) |-> ($past(state_q) == DB_FALL && $past(cnt_q) == CNT_LAST));

endmodule

// File: rtl/hpd_evt_regs.sv
module hpd_evt_regs
    import hpd_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sync,
    input  logic              hp_level,
    input  logic              hp_toggle,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic               rx_stat_q;
    logic [NUM_SRC-1:0] evt_q, en_q;
    logic [NUM_SRC-1:0] change, clr;
    logic [NUM_SRC-1:0] status;
    logic               sel_stat, sel_evt, sel_en;
    logic               unused_wbits;

    assign sel_stat = (addr == ADDR_W'(ADR_STAT));
    assign sel_evt  = (addr == ADDR_W'(ADR_EVT));
    assign sel_en   = (addr == ADDR_W'(ADR_EN));
    assign unused_wbits = ^wdata[DATA_W-1:NUM_SRC];

    always_comb begin
        status         = '0;
        status[BIT_RX] = rx_stat_q;
        status[BIT_HP] = hp_level;
        change         = '0;
        change[BIT_RX] = rx_sync ^ rx_stat_q;
        change[BIT_HP] = hp_toggle;
        clr            = (we && sel_evt) ? wdata[NUM_SRC-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_stat_q <= 1'b0;
            evt_q     <= '0;
            en_q      <= '0;
        end else begin
            rx_stat_q <= rx_sync;
            evt_q     <= (evt_q & ~clr) | change;
            if (we && sel_en) en_q <= wdata[NUM_SRC-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_stat)     rdata[NUM_SRC-1:0] = status;
        else if (sel_evt) rdata[NUM_SRC-1:0] = evt_q;
        else if (sel_en)  rdata[NUM_SRC-1:0] = en_q;
        irq = |(evt_q & en_q);
    end

    p_evt_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hp_toggle |=> evt_q[BIT_HP]);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_toggle && we && sel_evt && wdata[BIT_HP]) |=> evt_q[BIT_HP]);

    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel_evt && wdata[BIT_HP] && !hp_toggle) |=> !evt_q[BIT_HP]);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q[BIT_RX] && !(we && sel_evt && wdata[BIT_RX])) |=> evt_q[BIT_RX]);

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !we) |=> irq);

endmodule

// File: rtl/hpd_irq_ctrl.sv
module hpd_irq_ctrl
    import hpd_pkg::*;
#(
    parameter int DEB_CYCLES = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hpd_raw,
    input  logic              rx_present,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_drive_low
);
    logic [NUM_SRC-1:0] raw_in, synced;
    logic               hp_level, hp_toggle;

    always_comb begin
        raw_in         = '0;
        raw_in[BIT_RX] = rx_present;
        raw_in[BIT_HP] = hpd_raw;
    end

    hpd_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(raw_in), .q_sync(synced)
    );

    hpd_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk(clk), .rst_n(rst_n), .din(synced[BIT_HP]),
        .level(hp_level), .toggle_now(hp_toggle)
    );

    hpd_evt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .rx_sync(synced[BIT_RX]), .hp_level(hp_level), .hp_toggle(hp_toggle),
        .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
        .rdata(reg_rdata), .irq(irq_drive_low)
    );

    p_no_irq_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_drive_low);

endmodule

// File: tb/sim_hpd_irq_ctrl.sv
module sim_hpd_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hpd_raw = 1'b0;
    logic       rx_present = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_drive_low;

    int  checks = 0;
    int  failures = 0;
    logic pend = 1'b0;
    bit   done = 1'b0;

    logic [7:0] exp_q [$];
    bit         kind_q [$];
    string      tag_q [$];

    hpd_irq_ctrl #(.DEB_CYCLES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .hpd_raw(hpd_raw), .rx_present(rx_present),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_drive_low(irq_drive_low)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: pops expected items and compares away from the clock edge
    always @(negedge clk) begin
        #2;
        if (pend && exp_q.size() > 0) begin
            logic [7:0] e, a;
            bit k;
            string t;
            e = exp_q.pop_front();
            k = kind_q.pop_front();
            t = tag_q.pop_front();
            a = k ? {7'b0, irq_drive_low} : reg_rdata;
            checks++;
            if (a !== e) begin
                failures++;
                $display("FAIL %s actual=%02h expected=%02h", t, a, e);
            end
        end
    end

    // driver tasks: called at a falling edge, return at a falling edge
    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
        reg_addr = a;
        pend = 1'b1;
        exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
        @(negedge clk);
        pend = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        pend = 1'b1;
        exp_q.push_back({7'b0, e}); kind_q.push_back(1'b1); tag_q.push_back(t);
        @(negedge clk);
        pend = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        rd(4'd0, 8'h00, "R1 status");
        rd(4'd1, 8'h00, "R1 events");
        rd(4'd2, 8'h00, "R1 enable");
        chk_irq(1'b0, "R1 irq");

        // R4 re-timing: status flips after the third rising edge
        rx_present = 1'b1;
        rd(4'd0, 8'h00, "R4 before edge1");
        rd(4'd0, 8'h00, "R4 after edge1");
        rd(4'd0, 8'h00, "R4 after edge2");
        rd(4'd0, 8'h01, "R4 after edge3");
        // R5 event set, R7 enables do not gate events
        rd(4'd1, 8'h01, "R5 R7 rx event with enable off");
        chk_irq(1'b0, "R8 no irq without enable");

        // R7 enable register
        wr(4'd2, 8'hFF);
        rd(4'd2, 8'h03, "R7 enable readback upper bits zero");
        wr(4'd2, 8'h01);
        chk_irq(1'b1, "R8 irq with rx enabled");

        // R6 write 0 ignored, write 1 clears
        wr(4'd1, 8'h00);
        rd(4'd1, 8'h01, "R6 write0 no effect");
        wr(4'd1, 8'h01);
        rd(4'd1, 8'h00, "R6 write1 clears");
        chk_irq(1'b0, "R8 irq released");

        // R3 short hot-plug pulse ignored
        hpd_raw = 1'b1;
        cyc(N - 4);
        hpd_raw = 1'b0;
        cyc(N + 6);
        rd(4'd0, 8'h01, "R3 glitch status");
        rd(4'd1, 8'h00, "R3 glitch events");

        // R3 qualified rise
        hpd_raw = 1'b1;
        cyc(N + 6);
        rd(4'd0, 8'h03, "R3 hot-plug status set");
        rd(4'd1, 8'h02, "R5 hot-plug event");
        chk_irq(1'b0, "R8 hp event not enabled");
        wr(4'd2, 8'h02);
        chk_irq(1'b1, "R8 hp event enabled");

        // R2 status read-only, R10 unmapped
        wr(4'd0, 8'hFC);
        rd(4'd0, 8'h03, "R2 status write ignored");
        wr(4'd3, 8'hFF);
        rd(4'd3, 8'h00, "R10 unmapped read");
        rd(4'd1, 8'h02, "R10 events untouched");
        rd(4'd2, 8'h02, "R10 enable untouched");
        wr(4'd9, 8'hFF);
        rd(4'd1, 8'h02, "R10 high address write ignored");
        wr(4'd1, 8'h02);
        rd(4'd1, 8'h00, "R6 hp event cleared");

        // R9 set beats clear on the same edge
        rx_present = 1'b0;
        cyc(2);
        wr(4'd1, 8'h01);
        rd(4'd1, 8'h01, "R9 set wins");
        rd(4'd0, 8'h02, "R4 rx status fell");
        wr(4'd1, 8'h01);
        rd(4'd1, 8'h00, "R9 follow-up clear");

        // R3 R5 falling hot-plug
        hpd_raw = 1'b0;
        cyc(N - 4);
        rd(4'd0, 8'h02, "R3 fall not yet qualified");
        cyc(10);
        rd(4'd0, 8'h00, "R3 fall qualified");
        rd(4'd1, 8'h02, "R5 falling edge event");
        chk_irq(1'b1, "R8 irq on hp fall");

        cyc(2);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule